// File: doc/BRIEF.md
# Compact 32-bit Register-Machine Core

This block is a single-cycle 32-bit processor core for a small custom instruction set. Instructions come in over a valid/ready fetch stream. Each accepted word is decoded and executed in the cycle in which it is accepted. The instruction set has four classes: immediate load, arithmetic/logic, word load/store and two-register conditional jump. The register file holds 32 words. Register 0 always reads as zero. Register 31 is the program counter, and it can be read and written like any other register. Registers 29 and 30 are, by convention, the frame and stack pointers; the hardware treats them as ordinary registers.

Data accesses leave the core through a valid/ready memory port, which can be wired to RAM or to memory-mapped peripherals. Both streams follow the same rules for back-pressure:

- A fetch transfer happens in a cycle where `fetch_valid` and `fetch_ready` are both high.
- `fetch_ready` goes low only when the offered word is a load or a store and `mem_ready` is low. In that case the source must hold `fetch_word` stable.
- `mem_valid` is driven combinationally from the offered word.
- Load data on `mem_rdata` is taken in the cycle in which `mem_valid` and `mem_ready` are both high.

A second operand is always formed as register rs2 plus a sign-extended 9-bit offset. The ALU and the address generator both use that operand. Jumps compare two registers and go to a third register plus the offset.

Top module: `mini32_core`

## Requirements
- R1: After reset every register reads zero, `fetch_addr` is 0 and `mem_valid` is low while `fetch_valid` is low.
- R2: Register 0 reads as zero, and any write to it is discarded.
- R3: The class is in bits [31:29] and the sub-operation in bits [28:24]. Class 0 uses rd at [23:19] and a 16-bit immediate at [15:0]. Sub-op 0 writes rd = {16'h0, imm}. Sub-op 1 writes rd = {imm, rd[15:0]}.
- R4: Class 1 uses rd [23:19], rs1 [18:14], rs2 [13:9] and a signed offset [8:0], and writes rd = rs1 op (rs2 + offset). Sub-ops 0..7 select add, sub, shift-left, logical shift-right, arithmetic shift-right, and, or, xor.
- R5: The shift sub-ops (2, 3, 4) use only bits [4:0] of the adjusted operand as the shift amount.
- R6: Class 2 addresses rs1 + rs2 + offset with bits [1:0] forced to zero. Sub-op 0 loads `mem_rdata` into rd. Sub-op 1 drives rd on `mem_wdata` with `mem_we` high.
- R7: While `mem_valid` is high and `mem_ready` is low, `fetch_ready` is low and no architectural state changes.
- R8: In a cycle without a fetch transfer, no register and no `fetch_addr` changes, whatever `fetch_word` holds.
- R9: Class 3, sub-ops 0..3, test rs1 against rs2 for eq, ne, signed lt and signed ge. When the test holds, the next PC is rd + offset with bits [1:0] cleared; otherwise every non-redirecting instruction advances the PC by 4.
- R10: Reading register 31 gives the address of the current instruction. Any instruction that writes register 31 sets the next fetch address to the written value, with bits [1:0] cleared.
- R11: Undefined encodings (classes 4..7, class 0 sub-op > 1, class 1 sub-op > 7, class 2 sub-op > 1, class 3 sub-op > 3) change no register, raise no `mem_valid` and advance the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | output | 32 | Address of the instruction wanted next (register 31) |
| fetch_word | input | 32 | Instruction word offered |
| fetch_valid | input | 1 | Instruction word is valid |
| fetch_ready | output | 1 | Core accepts the offered word this cycle |
| mem_valid | output | 1 | Data access request |
| mem_ready | input | 1 | Memory completes the access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word-aligned data address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data |

## Verification
Two functions can fall in the same cycle: a memory access and a PC redirect, which happens when a load names register 31 as its destination. Control-flow changes through rd = 31 can also coincide with the implicit PC increment. The bench provokes both cases:

- A load into register 31 is returned with a chosen data word, and the next fetch address must equal that word, not the incremented PC.
- An ALU write to register 31 and a jump based on register 31 must each override the increment.

The bench also holds a load in a stall for several cycles. During the stall the fetch address and the registers must stay frozen. Once the access completes, exactly one write-back must occur.

// File: rtl/mini32_pkg.sv
package mini32_pkg;
  localparam int XLEN     = 32;
  localparam int NUM_REGS = 32;
  localparam int REG_AW   = $clog2(NUM_REGS);
  localparam int PC_REG   = NUM_REGS - 1;
  localparam int UIMM_W   = 16;
  localparam int SIMM_W   = 9;
  localparam int SHAMT_W  = $clog2(XLEN);

  typedef enum logic [2:0] {
    CLS_IMM = 3'd0,
    CLS_ALU = 3'd1,
    CLS_MEM = 3'd2,
    CLS_JMP = 3'd3
  } cls_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_SHL = 3'd2, OP_SHR = 3'd3,
    OP_SRA = 3'd4, OP_AND = 3'd5, OP_OR  = 3'd6, OP_XOR = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0, CMP_NE = 2'd1, CMP_LT = 2'd2, CMP_GE = 2'd3
  } cmp_e;

  typedef struct packed {
    logic              wr;
    logic [REG_AW-1:0] rd;
    logic [REG_AW-1:0] rs1;
    logic [REG_AW-1:0] rs2;
    logic [XLEN-1:0]   simm;
    logic [UIMM_W-1:0] uimm;
    logic              lo_imm;
    logic              hi_imm;
    logic              alu;
    logic              ld;
    logic              st;
    logic              jmp;
    alu_op_e           aop;
    cmp_e              cmp;
  } dec_t;
endpackage

// File: rtl/mini32_decode.sv
module mini32_decode
  import mini32_pkg::*;
(
  input  logic [XLEN-1:0] word,
  output dec_t            dec
);
  logic [2:0] cls;
  logic [4:0] sub;

  assign cls = word[31:29];
  assign sub = word[28:24];

  always_comb begin
    dec        = '0;
    dec.rd     = word[23:19];
    dec.rs1    = word[18:14];
    dec.rs2    = word[13:9];
    dec.simm   = {{(XLEN-SIMM_W){word[SIMM_W-1]}}, word[SIMM_W-1:0]};
    dec.uimm   = word[UIMM_W-1:0];
    dec.aop    = alu_op_e'(sub[2:0]);
    dec.cmp    = cmp_e'(sub[1:0]);
    case (cls)
      CLS_IMM: begin
        dec.lo_imm = (sub == 5'd0);
        dec.hi_imm = (sub == 5'd1);
        dec.wr     = (sub < 5'd2);
      end
      CLS_ALU: begin
        dec.alu = (sub < 5'd8);
        dec.wr  = (sub < 5'd8);
      end
      CLS_MEM: begin
        dec.ld = (sub == 5'd0);
        dec.st = (sub == 5'd1);
        dec.wr = (sub == 5'd0);
      end
      CLS_JMP: dec.jmp = (sub < 5'd4);
      default: ;
    endcase
  end
endmodule

// File: rtl/mini32_regfile.sv
module mini32_regfile
  import mini32_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] ra_addr,
  input  logic [REG_AW-1:0] rb_addr,
  input  logic [REG_AW-1:0] rc_addr,
  output logic [XLEN-1:0]   ra_data,
  output logic [XLEN-1:0]   rb_data,
  output logic [XLEN-1:0]   rc_data,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [XLEN-1:0]   wr_data,
  input  logic              pc_we,
  input  logic [XLEN-1:0]   pc_d,
  output logic [XLEN-1:0]   pc_q
);
  logic [XLEN-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++)
        regs[i] <= (i == PC_REG) ? RESET_PC : '0;
    end else begin
      if (wr_en && wr_addr != '0 && wr_addr != REG_AW'(PC_REG))
        regs[wr_addr] <= wr_data;
      if (pc_we)
        regs[PC_REG] <= pc_d;
    end
  end

  assign ra_data = (ra_addr == '0) ? '0 : regs[ra_addr];
  assign rb_data = (rb_addr == '0) ? '0 : regs[rb_addr];
  assign rc_data = (rc_addr == '0) ? '0 : regs[rc_addr];
  assign pc_q    = regs[PC_REG];

  a_r2_zero_stays_zero: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);
endmodule

// File: rtl/mini32_alu.sv
module mini32_alu
  import mini32_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y
);
  logic [SHAMT_W-1:0] sh;
  assign sh = b[SHAMT_W-1:0];

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_SHL:  y = a << sh;
      OP_SHR:  y = a >> sh;
      OP_SRA:  y = XLEN'($signed(a) >>> sh);
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      default: y = a ^ b;
    endcase
  end
endmodule

// File: rtl/mini32_core.sv
module mini32_core
  import mini32_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
)(
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] fetch_addr,
  input  logic [XLEN-1:0] fetch_word,
  input  logic            fetch_valid,
  output logic            fetch_ready,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  input  logic [XLEN-1:0] mem_rdata
);
  localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);
  localparam logic [XLEN-1:0] STEP      = XLEN'(4);

  dec_t            dec;
  logic [XLEN-1:0] rs1_v, rs2_v, rd_v, pc_q;
  logic [XLEN-1:0] opb, alu_y, ea, target, wb, pc_next;
  logic            commit, taken, redirect, is_mem;

  mini32_decode u_dec (.word(fetch_word), .dec(dec));

  mini32_regfile #(.RESET_PC(RESET_PC)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_addr(dec.rs1), .rb_addr(dec.rs2), .rc_addr(dec.rd),
    .ra_data(rs1_v), .rb_data(rs2_v), .rc_data(rd_v),
    .wr_en(commit && dec.wr), .wr_addr(dec.rd), .wr_data(wb),
    .pc_we(commit), .pc_d(pc_next), .pc_q(pc_q)
  );

  // second operand: register plus signed offset, shared by ALU and address
  assign opb = rs2_v + dec.simm;

  mini32_alu u_alu (.a(rs1_v), .b(opb), .op(dec.aop), .y(alu_y));

  assign ea     = rs1_v + opb;
  assign target = rd_v + dec.simm;

  always_comb begin
    case (dec.cmp)
      CMP_EQ:  taken = (rs1_v == rs2_v);
      CMP_NE:  taken = (rs1_v != rs2_v);
      CMP_LT:  taken = ($signed(rs1_v) <  $signed(rs2_v));
      default: taken = ($signed(rs1_v) >= $signed(rs2_v));
    endcase
    taken = taken && dec.jmp;
  end

  always_comb begin
    if (dec.lo_imm)      wb = {{(XLEN-UIMM_W){1'b0}}, dec.uimm};
    else if (dec.hi_imm) wb = {dec.uimm, rd_v[UIMM_W-1:0]};
    else if (dec.ld)     wb = mem_rdata;
    else                 wb = alu_y;
  end

  assign is_mem      = dec.ld || dec.st;
  assign fetch_ready = !is_mem || mem_ready;
  assign commit      = fetch_valid && fetch_ready;
  assign redirect    = dec.wr && (dec.rd == REG_AW'(PC_REG));

  always_comb begin
    if (redirect)   pc_next = wb & WORD_MASK;
    else if (taken) pc_next = target & WORD_MASK;
    else            pc_next = pc_q + STEP;
  end

  assign fetch_addr = pc_q;
  assign mem_valid  = fetch_valid && is_mem;
  assign mem_we     = mem_valid && dec.st;
  assign mem_addr   = ea & WORD_MASK;
  assign mem_wdata  = rd_v;

  a_r8_idle_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> $stable(fetch_addr));

  a_r7_stall_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> $stable(fetch_addr));

  a_r9_fall_through: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !taken && !redirect) |=> fetch_addr == $past(fetch_addr) + STEP);

  a_r9_taken_target: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && taken && !redirect) |=> fetch_addr == ($past(target) & WORD_MASK));

  a_r10_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && redirect) |=> fetch_addr == ($past(wb) & WORD_MASK));

  a_r6_aligned_access: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);
endmodule

// File: tb/mini32_core_tb.sv
module mini32_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_addr, fetch_word, mem_addr, mem_wdata, mem_rdata;
  logic        fetch_valid, fetch_ready, mem_valid, mem_ready, mem_we;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] exp_pc;

  always #10 clk = ~clk;

  mini32_core u_dut (
    .clk(clk), .rst_n(rst_n),
    .fetch_addr(fetch_addr), .fetch_word(fetch_word),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  typedef struct packed {
    logic [2:0]  mop;
    logic [4:0]  sop;
    logic [4:0]  rd;
    logic [4:0]  a;
    logic [4:0]  b;
    logic [15:0] imm;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 5'd0, 5'd1,  5'd0, 5'd0, 16'h1234, 32'h00001234},
    '{3'd0, 5'd1, 5'd1,  5'd0, 5'd0, 16'hABCD, 32'hABCD1234},
    '{3'd0, 5'd0, 5'd2,  5'd0, 5'd0, 16'h0005, 32'h00000005},
    '{3'd1, 5'd0, 5'd3,  5'd1, 5'd2, 16'h0000, 32'hABCD1239},
    '{3'd1, 5'd1, 5'd4,  5'd2, 5'd1, 16'h0000, 32'h5432EDD1},
    '{3'd1, 5'd0, 5'd5,  5'd2, 5'd0, 16'h01FD, 32'h00000002},
    '{3'd1, 5'd2, 5'd6,  5'd1, 5'd2, 16'h0000, 32'h79A24680},
    '{3'd1, 5'd3, 5'd7,  5'd1, 5'd2, 16'h0000, 32'h055E6891},
    '{3'd1, 5'd4, 5'd8,  5'd1, 5'd2, 16'h0000, 32'hFD5E6891},
    '{3'd1, 5'd5, 5'd9,  5'd1, 5'd3, 16'h0000, 32'hABCD1230},
    '{3'd1, 5'd6, 5'd10, 5'd1, 5'd3, 16'h0000, 32'hABCD123D},
    '{3'd1, 5'd7, 5'd11, 5'd1, 5'd3, 16'h0000, 32'h0000000D},
    '{3'd1, 5'd2, 5'd12, 5'd2, 5'd2, 16'h001B, 32'h00000005},
    '{3'd0, 5'd0, 5'd0,  5'd0, 5'd0, 16'hFFFF, 32'h00000000},
    '{3'd1, 5'd0, 5'd13, 5'd0, 5'd0, 16'h01FF, 32'hFFFFFFFF},
    '{3'd0, 5'd1, 5'd11, 5'd0, 5'd0, 16'hFFFF, 32'hFFFF000D},
    '{3'd0, 5'd0, 5'd11, 5'd0, 5'd0, 16'h0007, 32'h00000007}
  };

  function automatic logic [31:0] enc(logic [2:0] mop, logic [4:0] sop,
      logic [4:0] rd, logic [4:0] a, logic [4:0] b, logic [15:0] imm);
    if (mop == 3'd0) return {mop, sop, rd, 3'b000, imm};
    return {mop, sop, rd, a, b, imm[8:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [31:0] w, logic rdy, logic [31:0] rdata);
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_word  = w;
    mem_ready   = rdy;
    mem_rdata   = rdata;
    #2;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    fetch_valid = 1'b0;
    mem_ready   = 1'b0;
  endtask

  task automatic run(logic [31:0] w);
    drive(w, 1'b1, 32'h0);
    step();
    exp_pc += 4;
  endtask

  task automatic peek(logic [4:0] r, logic [31:0] exp, string tag);
    drive(enc(3'd2, 5'd1, r, 5'd0, 5'd0, 16'h0), 1'b1, 32'h0);
    chk(tag, mem_wdata, exp);
    step();
    exp_pc += 4;
  endtask

  task automatic flow(logic [31:0] w, logic [31:0] rdata, logic [31:0] nxt, string tag);
    drive(w, 1'b1, rdata);
    step();
    exp_pc = nxt;
    chk(tag, fetch_addr, exp_pc);
  endtask

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    string tag;
    logic [31:0] p;
    fetch_valid = 1'b0; fetch_word = '0; mem_ready = 1'b0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1 reset state
    chk("R1 fetch_addr", fetch_addr, 32'h0);
    chk("R1 mem_valid", {31'h0, mem_valid}, 32'h0);
    exp_pc = 32'h0;
    peek(5'd13, 32'h0, "R1 reg cleared");

    // table of instructions, each followed by a read-out store
    for (int i = 0; i < NV; i++) begin
      run(enc(VEC[i].mop, VEC[i].sop, VEC[i].rd, VEC[i].a, VEC[i].b, VEC[i].imm));
      if (VEC[i].rd == 5'd0)      tag = "R2 r0 write";
      else if (VEC[i].mop == 3'd0) tag = "R3 imm load";
      else if (VEC[i].sop inside {5'd2, 5'd3, 5'd4}) tag = "R5 shift";
      else                          tag = "R4 alu";
      peek(VEC[i].rd, VEC[i].exp, tag);
    end
    chk("R9 sequential pc", fetch_addr, exp_pc);

    // R8 word offered without valid is ignored
    @(negedge clk);
    fetch_word = enc(3'd0, 5'd0, 5'd3, 5'd0, 5'd0, 16'hFFFF);
    fetch_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 pc idle", fetch_addr, exp_pc);
    peek(5'd3, 32'hABCD1239, "R8 reg idle");

    // R6 store and load
    run(enc(3'd0, 5'd0, 5'd14, 5'd0, 5'd0, 16'h0100));
    drive(enc(3'd2, 5'd1, 5'd3, 5'd14, 5'd2, 16'h01FF), 1'b1, 32'h0);
    chk("R6 store valid", {31'h0, mem_valid & mem_we}, 32'h1);
    chk("R6 store addr", mem_addr, 32'h104);
    chk("R6 store data", mem_wdata, 32'hABCD1239);
    step(); exp_pc += 4;
    drive(enc(3'd2, 5'd0, 5'd15, 5'd14, 5'd0, 16'h0006), 1'b1, 32'hCAFEF00D);
    chk("R6 load aligned addr", mem_addr, 32'h104);
    chk("R6 load not write", {31'h0, mem_we}, 32'h0);
    step(); exp_pc += 4;
    peek(5'd15, 32'hCAFEF00D, "R6 load data");

    // R7 stalled load
    drive(enc(3'd2, 5'd0, 5'd16, 5'd14, 5'd2, 16'h0003), 1'b0, 32'hDEAD0000);
    chk("R7 stall ready", {31'h0, fetch_ready}, 32'h0);
    step();
    chk("R7 stall pc", fetch_addr, exp_pc);
    drive(enc(3'd2, 5'd0, 5'd16, 5'd14, 5'd2, 16'h0003), 1'b0, 32'hDEAD0000);
    chk("R7 stall addr", mem_addr, 32'h108);
    step();
    drive(enc(3'd2, 5'd0, 5'd16, 5'd14, 5'd2, 16'h0003), 1'b1, 32'h12345678);
    chk("R7 release ready", {31'h0, fetch_ready}, 32'h1);
    step(); exp_pc += 4;
    peek(5'd16, 32'h12345678, "R7 single write-back");

    // R9 jumps, base r14 = 0x100, r1 negative, r2 = 5
    flow(enc(3'd3, 5'd0, 5'd14, 5'd2, 5'd2, 16'h0008), 0, 32'h108, "R9 eq taken");
    flow(enc(3'd3, 5'd1, 5'd14, 5'd2, 5'd2, 16'h0008), 0, 32'h10C, "R9 ne not taken");
    flow(enc(3'd3, 5'd2, 5'd14, 5'd1, 5'd2, 16'h0020), 0, 32'h120, "R9 signed lt taken");
    flow(enc(3'd3, 5'd3, 5'd14, 5'd1, 5'd2, 16'h0020), 0, 32'h124, "R9 signed ge not taken");
    flow(enc(3'd3, 5'd3, 5'd14, 5'd2, 5'd1, 16'h01FC), 0, 32'h0FC, "R9 ge back taken");
    flow(enc(3'd3, 5'd0, 5'd14, 5'd0, 5'd0, 16'h0003), 0, 32'h100, "R9 target aligned");

    // R10 register 31 as operand and destination
    p = exp_pc;
    run(enc(3'd1, 5'd0, 5'd17, 5'd31, 5'd0, 16'h0000));
    peek(5'd17, p, "R10 read pc");
    flow(enc(3'd1, 5'd0, 5'd31, 5'd14, 5'd0, 16'h0040), 0, 32'h140, "R10 alu redirect");
    flow(enc(3'd3, 5'd0, 5'd31, 5'd0, 5'd0, 16'h0010), 0, 32'h150, "R10 pc relative jump");
    flow(enc(3'd2, 5'd0, 5'd31, 5'd0, 5'd0, 16'h0000), 32'h200, 32'h200, "R10 load redirect");
    flow(enc(3'd0, 5'd0, 5'd31, 5'd0, 5'd0, 16'h0302), 0, 32'h300, "R10 imm redirect");

    // R11 undefined encodings
    drive(enc(3'd5, 5'd0, 5'd3, 5'd1, 5'd2, 16'h0055), 1'b1, 32'h0);
    chk("R11 no mem", {31'h0, mem_valid}, 32'h0);
    step(); exp_pc += 4;
    chk("R11 pc step", fetch_addr, exp_pc);
    drive(enc(3'd2, 5'd2, 5'd3, 5'd14, 5'd0, 16'h0000), 1'b1, 32'h0);
    chk("R11 mem subop", {31'h0, mem_valid}, 32'h0);
    step(); exp_pc += 4;
    run(enc(3'd1, 5'd9, 5'd3, 5'd1, 5'd2, 16'h0000));
    run(enc(3'd0, 5'd2, 5'd3, 5'd0, 5'd0, 16'h0001));
    peek(5'd3, 32'hABCD1239, "R11 reg kept");
    chk("R11 pc after", fetch_addr, exp_pc);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule